// File: doc/BRIEF.md
# Flash Array Controller with Gated Program and Erase

This block models an on-chip NOR-style flash array together with a small store of user configuration words, and exposes three 32-bit word-access ports: a control window holding a mode register, a status word and the erase command registers; a read/write window onto the configuration words; and a program/read port into the flash array. Programming follows NOR rules: a write can only clear bits, so the stored word becomes the AND of its old contents and the new data.

Two mode bits gate the array: one allows programming and one allows erasure. Three erase commands exist. A page erase takes a byte address, drops the in-page bits and fills that page with ones, provided erasure is allowed and the page lies inside the array; it can be issued through either of two equivalent registers. A whole-array erase needs the erase code and erasure allowed, and clears the configuration words too. A configuration-only erase needs only the erase code. The array geometry (page count and page size) is set by parameters; 256 pages of 1 KiB give a 256 KiB array.

Top module: `nvm_ctrl`

## Requirements
- R1: The mode register at control offset 0x04 keeps bit 0 (program enable) and bit 1 (erase enable); all other written bits are dropped and read as zero. It resets to zero.
- R2: Control offset 0x00 always reads as 0x00000001 (ready).
- R3: Reading any control offset other than 0x00 and 0x04 returns zero; writes to offsets other than 0x04, 0x08, 0x0C, 0x10 and 0x14 change nothing.
- R4: A flash word write takes effect only while program enable is set, and stores old AND new data.
- R5: A page erase (byte address written to 0x08) ignores the in-page address bits and fills the whole page with ones; it does nothing while erase enable is clear.
- R6: A page erase whose address is at or beyond the array size changes nothing.
- R7: Offset 0x10 is a second page-erase register with the same behaviour as 0x08.
- R8: Writing 0x00000001 to 0x0C while erase enable is set fills every flash word and every configuration word with ones; any other value, or erase enable clear, changes nothing.
- R9: Writing 0x00000001 to 0x14 fills every configuration word with ones whatever the mode bits; any other value changes nothing.
- R10: Configuration words are plain read/write 32-bit words (no AND rule) and reset to all ones.
- R11: Every read port returns, one clock after the address is presented, the contents as they were before any write on that same edge.
- R12: When an erase covering a word and a program of that word land on the same edge, the erase wins and the word reads all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctl_addr | input | 8 | Control window byte offset |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 32 | Control write data |
| ctl_rdata | output | 32 | Control read data, one cycle after address |
| cfg_widx | input | log2(USER_WORDS) | Configuration word index |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data, one cycle after index |
| fl_widx | input | log2(array words) | Flash word index |
| fl_we | input | 1 | Flash program strobe |
| fl_wdata | input | 32 | Flash program data |
| fl_rdata | output | 32 | Flash read data, one cycle after index |

## Verification
Every write and erase becomes visible on the edge that samples its strobe, and every read port is registered, so a result is due on the second edge after the stimulus when the read is presented on the following cycle, and one edge after the address for an undisturbed word. The bench drives on the falling edge, presents each read index for exactly one cycle and samples on the next falling edge, which lands after the registered read. The same-edge cases (read of a word being programmed, erase against program) are checked on both the first and the second sample to pin the old-then-new ordering.

// File: rtl/nvm_pkg.sv
package nvm_pkg;

   localparam logic [31:0] ERASE_CODE = 32'h0000_0001;

   localparam logic [7:0] OFS_STATUS = 8'h00;
   localparam logic [7:0] OFS_MODE   = 8'h04;
   localparam logic [7:0] OFS_PAGE_A = 8'h08;
   localparam logic [7:0] OFS_FULL   = 8'h0C;
   localparam logic [7:0] OFS_PAGE_B = 8'h10;
   localparam logic [7:0] OFS_USER   = 8'h14;

   typedef struct packed {
      logic erase_en;
      logic prog_en;
   } mode_t;

endpackage

// File: rtl/nvm_ctl_regs.sv
module nvm_ctl_regs
   import nvm_pkg::*;
#(
   parameter int ARRAY_BYTES = 8192
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [7:0]  addr,
   input  logic        we,
   input  logic [31:0] wdata,
   output logic [31:0] rdata,
   output mode_t       mode_q,
   output logic        page_erase,
   output logic        full_erase,
   output logic        user_erase
);

   logic in_range;
   logic is_code;

   assign in_range   = {1'b0, wdata} < 33'(ARRAY_BYTES);
   assign is_code    = (wdata == ERASE_CODE);
   assign page_erase = we && ((addr == OFS_PAGE_A) || (addr == OFS_PAGE_B))
                       && mode_q.erase_en && in_range;
   assign full_erase = we && (addr == OFS_FULL) && is_code && mode_q.erase_en;
   assign user_erase = we && (addr == OFS_USER) && is_code;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
      end else if (we && (addr == OFS_MODE)) begin
         mode_q <= mode_t'(wdata[1:0]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
      end else begin
         case (addr)
            OFS_STATUS: rdata <= 32'h0000_0001;
            OFS_MODE:   rdata <= {30'd0, mode_q};
            default:    rdata <= '0;
         endcase
      end
   end

endmodule

// File: rtl/nvm_flash_array.sv
module nvm_flash_array #(
   parameter int NUM_PAGES  = 8,
   parameter int PAGE_WORDS = 256,
   localparam int WORDS = NUM_PAGES * PAGE_WORDS,
   localparam int WA_W  = $clog2(WORDS),
   localparam int PG_W  = $clog2(NUM_PAGES),
   localparam int WO_W  = $clog2(PAGE_WORDS)
) (
   input  logic            clk,
   input  logic [WA_W-1:0] widx,
   input  logic            we,
   input  logic [31:0]     wdata,
   input  logic            prog_en,
   input  logic            page_erase,
   input  logic [PG_W-1:0] page_idx,
   input  logic            full_erase,
   output logic [31:0]     rdata
);

   logic [31:0] mem [WORDS];

   always_ff @(posedge clk) begin
      rdata <= mem[widx];
      if (full_erase) begin
         for (int w = 0; w < WORDS; w++) begin
            mem[w] <= '1;
         end
      end else if (page_erase) begin
         for (int w = 0; w < PAGE_WORDS; w++) begin
            mem[{page_idx, WO_W'(w)}] <= '1;
         end
      end else if (we && prog_en) begin
         mem[widx] <= mem[widx] & wdata;
      end
   end

endmodule

// File: rtl/nvm_user_words.sv
module nvm_user_words #(
   parameter int N_WORDS = 64,
   localparam int IX_W = $clog2(N_WORDS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [IX_W-1:0] widx,
   input  logic            we,
   input  logic [31:0]     wdata,
   input  logic            erase,
   output logic [31:0]     rdata
);

   logic [31:0] words [N_WORDS];

   for (genvar k = 0; k < N_WORDS; k++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            words[k] <= '1;
         end else if (erase) begin
            words[k] <= '1;
         end else if (we && (widx == IX_W'(k))) begin
            words[k] <= wdata;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
      end else begin
         rdata <= words[widx];
      end
   end

endmodule

// File: rtl/nvm_ctrl.sv
module nvm_ctrl
   import nvm_pkg::*;
#(
   parameter int NUM_PAGES  = 8,
   parameter int PAGE_BYTES = 1024,
   parameter int USER_WORDS = 64,
   localparam int ARRAY_BYTES = NUM_PAGES * PAGE_BYTES,
   localparam int PAGE_WORDS  = PAGE_BYTES / 4,
   localparam int FL_WW       = $clog2(ARRAY_BYTES / 4),
   localparam int CFG_W       = $clog2(USER_WORDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [7:0]       ctl_addr,
   input  logic             ctl_we,
   input  logic [31:0]      ctl_wdata,
   output logic [31:0]      ctl_rdata,
   input  logic [CFG_W-1:0] cfg_widx,
   input  logic             cfg_we,
   input  logic [31:0]      cfg_wdata,
   output logic [31:0]      cfg_rdata,
   input  logic [FL_WW-1:0] fl_widx,
   input  logic             fl_we,
   input  logic [31:0]      fl_wdata,
   output logic [31:0]      fl_rdata
);

   localparam int PB_LOG = $clog2(PAGE_BYTES);
   localparam int AB_LOG = $clog2(ARRAY_BYTES);

   if (PAGE_BYTES < 8 || (PAGE_BYTES & (PAGE_BYTES - 1)) != 0) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two of at least 8");
   end
   if (NUM_PAGES < 2 || (NUM_PAGES & (NUM_PAGES - 1)) != 0) begin : g_bad_pages
      $error("NUM_PAGES must be a power of two of at least 2");
   end
   if (USER_WORDS < 2 || (USER_WORDS & (USER_WORDS - 1)) != 0) begin : g_bad_user
      $error("USER_WORDS must be a power of two of at least 2");
   end

   mode_t mode_q;
   logic  page_erase;
   logic  full_erase;
   logic  user_erase;

   nvm_ctl_regs #(
      .ARRAY_BYTES(ARRAY_BYTES)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .addr       (ctl_addr),
      .we         (ctl_we),
      .wdata      (ctl_wdata),
      .rdata      (ctl_rdata),
      .mode_q     (mode_q),
      .page_erase (page_erase),
      .full_erase (full_erase),
      .user_erase (user_erase)
   );

   nvm_flash_array #(
      .NUM_PAGES  (NUM_PAGES),
      .PAGE_WORDS (PAGE_WORDS)
   ) u_array (
      .clk        (clk),
      .widx       (fl_widx),
      .we         (fl_we),
      .wdata      (fl_wdata),
      .prog_en    (mode_q.prog_en),
      .page_erase (page_erase),
      .page_idx   (ctl_wdata[AB_LOG-1:PB_LOG]),
      .full_erase (full_erase),
      .rdata      (fl_rdata)
   );

   nvm_user_words #(
      .N_WORDS (USER_WORDS)
   ) u_user (
      .clk   (clk),
      .rst_n (rst_n),
      .widx  (cfg_widx),
      .we    (cfg_we),
      .wdata (cfg_wdata),
      .erase (user_erase || full_erase),
      .rdata (cfg_rdata)
   );

endmodule

// File: rtl/nvm_ctrl_chk.sv
module nvm_ctrl_chk
   import nvm_pkg::*;
(
   input logic        clk,
   input logic        rst_n,
   input logic [7:0]  ctl_addr,
   input logic        ctl_we,
   input logic [31:0] ctl_wdata,
   input logic [31:0] ctl_rdata,
   input logic        cfg_we,
   input logic [31:0] cfg_rdata,
   input logic [1:0]  mode_bits
);

   logic undef_rd;
   assign undef_rd = (ctl_addr != OFS_STATUS) && (ctl_addr != OFS_MODE);

   assert_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_addr == OFS_STATUS) |=> (ctl_rdata == 32'h0000_0001));

   assert_undef_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
      undef_rd |=> (ctl_rdata == 32'h0));

   assert_mode_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_we && ctl_addr == OFS_MODE) |=> (mode_bits == $past(ctl_wdata[1:0])));

   assert_mode_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !(ctl_we && ctl_addr == OFS_MODE) |=> $stable(mode_bits));

   assert_user_erase_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_we && ctl_addr == OFS_USER && ctl_wdata == ERASE_CODE) ##1 !cfg_we
      |=> (cfg_rdata == 32'hFFFF_FFFF));

endmodule

bind nvm_ctrl nvm_ctrl_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ctl_addr  (ctl_addr),
   .ctl_we    (ctl_we),
   .ctl_wdata (ctl_wdata),
   .ctl_rdata (ctl_rdata),
   .cfg_we    (cfg_we),
   .cfg_rdata (cfg_rdata),
   .mode_bits (mode_q)
);

// File: tb/sim_nvm_ctrl.sv
module sim_nvm_ctrl;

   localparam int NP = 8;
   localparam int PB = 256;
   localparam int UW = 64;
   localparam int PW = PB / 4;
   localparam int NW = NP * PW;
   localparam int AB = NP * PB;
   localparam int FW = $clog2(NW);
   localparam int CW = $clog2(UW);

   logic          clk = 1'b0;
   logic          rst_n;
   logic [7:0]    ctl_addr;
   logic          ctl_we;
   logic [31:0]   ctl_wdata;
   logic [31:0]   ctl_rdata;
   logic [CW-1:0] cfg_widx;
   logic          cfg_we;
   logic [31:0]   cfg_wdata;
   logic [31:0]   cfg_rdata;
   logic [FW-1:0] fl_widx;
   logic          fl_we;
   logic [31:0]   fl_wdata;
   logic [31:0]   fl_rdata;

   always #10 clk = ~clk;

   nvm_ctrl #(.NUM_PAGES(NP), .PAGE_BYTES(PB), .USER_WORDS(UW)) u0 (
      .clk(clk), .rst_n(rst_n),
      .ctl_addr(ctl_addr), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
      .cfg_widx(cfg_widx), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .fl_widx(fl_widx), .fl_we(fl_we), .fl_wdata(fl_wdata), .fl_rdata(fl_rdata)
   );

   logic [31:0] fm [NW];
   logic [31:0] um [UW];
   logic [1:0]  md;
   int checks = 0;
   int errors = 0;

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] ctl_exp(logic [7:0] a);
      if (a == 8'h00) return 32'h1;
      if (a == 8'h04) return {30'd0, md};
      return 32'h0;
   endfunction

   function automatic void model_ctl(logic [7:0] a, logic [31:0] d);
      case (a)
         8'h04: md = d[1:0];
         8'h08, 8'h10:
            if (md[1] && d < AB)
               for (int w = 0; w < PW; w++) fm[(d / PB) * PW + w] = '1;
         8'h0C:
            if (md[1] && d == 32'h1) begin
               for (int w = 0; w < NW; w++) fm[w] = '1;
               for (int u = 0; u < UW; u++) um[u] = '1;
            end
         8'h14:
            if (d == 32'h1) for (int u = 0; u < UW; u++) um[u] = '1;
         default: ;
      endcase
   endfunction

   // all tasks enter and leave at a falling edge
   task automatic ctl_wr(logic [7:0] a, logic [31:0] d);
      ctl_addr = a; ctl_wdata = d; ctl_we = 1'b1;
      @(negedge clk);
      ctl_we = 1'b0;
      model_ctl(a, d);
   endtask

   task automatic fl_wr(int i, logic [31:0] d);
      fl_widx = FW'(i); fl_wdata = d; fl_we = 1'b1;
      @(negedge clk);
      fl_we = 1'b0;
      if (md[0]) fm[i] = fm[i] & d;
   endtask

   task automatic cfg_wr(int i, logic [31:0] d);
      cfg_widx = CW'(i); cfg_wdata = d; cfg_we = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0;
      um[i] = d;
   endtask

   task automatic ctl_rd(string req, logic [7:0] a);
      ctl_addr = a;
      @(negedge clk);
      chk(req, ctl_rdata, ctl_exp(a));
   endtask

   task automatic fl_rd(string req, int i);
      fl_widx = FW'(i);
      @(negedge clk);
      chk(req, fl_rdata, fm[i]);
   endtask

   task automatic cfg_rd(string req, int i);
      cfg_widx = CW'(i);
      @(negedge clk);
      chk(req, cfg_rdata, um[i]);
   endtask

   task automatic full_cmp(string req);
      for (int w = 0; w < NW; w++) fl_rd(req, w);
      for (int u = 0; u < UW; u++) cfg_rd(req, u);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int unsigned seed;
      seed = $urandom(32'd41729);
      rst_n = 1'b0;
      ctl_addr = '0; ctl_we = 1'b0; ctl_wdata = '0;
      cfg_widx = '0; cfg_we = 1'b0; cfg_wdata = '0;
      fl_widx = '0; fl_we = 1'b0; fl_wdata = '0;
      md = 2'b00;
      for (int w = 0; w < NW; w++) fm[w] = '1;
      for (int u = 0; u < UW; u++) um[u] = '1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      ctl_rd("R1 mode reset", 8'h04);
      ctl_rd("R2 ready", 8'h00);
      ctl_rd("R3 undefined read", 8'h18);
      ctl_rd("R3 undefined read", 8'hFC);
      for (int u = 0; u < UW; u++) cfg_rd("R10 user reset ones", u);

      // mode masking, undefined write
      ctl_wr(8'h04, 32'hFFFF_FFFC);
      ctl_rd("R1 mode masked", 8'h04);
      ctl_wr(8'h04, 32'hFFFF_FFFF);
      ctl_rd("R1 mode two bits", 8'h04);
      ctl_wr(8'h18, 32'h0000_0000);
      ctl_wr(8'h40, 32'h0000_0001);
      ctl_rd("R3 undefined write ignored", 8'h04);

      // bring flash to a known state
      ctl_wr(8'h0C, 32'h1);
      full_cmp("R8 full erase");

      // programming: AND rule and gating
      fl_wr(5, 32'hF0F0_FF00);
      fl_wr(5, 32'h0FF0_F0F0);
      fl_rd("R4 and twice", 5);
      ctl_wr(8'h04, 32'h2);
      fl_wr(6, 32'h0000_0000);
      fl_rd("R4 program disabled", 6);

      // read returns old contents on a same-edge write
      ctl_wr(8'h04, 32'h3);
      fl_widx = FW'(9); fl_wdata = 32'h1234_0000; fl_we = 1'b1;
      @(negedge clk);
      fl_we = 1'b0;
      chk("R11 old data on same edge", fl_rdata, 32'hFFFF_FFFF);
      fm[9] = 32'h1234_0000;
      @(negedge clk);
      chk("R11 new data next cycle", fl_rdata, 32'h1234_0000);

      // page erase with in-page bits set, disabled, out of range, second register
      for (int w = 0; w < NW; w++) fl_wr(w, 32'h0);
      ctl_wr(8'h08, 32'(PB + 8'h3C));
      fl_rd("R5 page erase first", PW);
      fl_rd("R5 page erase last", 2 * PW - 1);
      fl_rd("R5 neighbour untouched", PW - 1);
      fl_rd("R5 neighbour untouched", 2 * PW);
      ctl_wr(8'h04, 32'h1);
      ctl_wr(8'h08, 32'(3 * PB));
      fl_rd("R5 erase disabled", 3 * PW);
      ctl_wr(8'h04, 32'h3);
      ctl_wr(8'h08, 32'(AB));
      ctl_wr(8'h10, 32'hFFFF_FFFF);
      ctl_wr(8'h08, 32'(AB + PB));
      full_cmp("R6 out of range ignored");
      ctl_wr(8'h10, 32'(5 * PB + 4));
      fl_rd("R7 second page register", 5 * PW + 17);
      fl_rd("R7 neighbour untouched", 6 * PW);

      // same edge erase vs program
      ctl_addr = 8'h08; ctl_wdata = 32'(2 * PB); ctl_we = 1'b1;
      fl_widx = FW'(2 * PW + 3); fl_wdata = 32'h0; fl_we = 1'b1;
      @(negedge clk);
      ctl_we = 1'b0; fl_we = 1'b0;
      model_ctl(8'h08, 32'(2 * PB));
      fl_rd("R12 erase beats program", 2 * PW + 3);

      // user words
      cfg_wr(3, 32'h0000_0000);
      cfg_wr(3, 32'hA5A5_5A5A);
      cfg_rd("R10 plain write", 3);
      cfg_wr(63, 32'h0000_0001);
      ctl_wr(8'h14, 32'h2);
      cfg_rd("R9 wrong code ignored", 3);
      ctl_wr(8'h04, 32'h0);
      ctl_wr(8'h14, 32'h1);
      cfg_rd("R9 user erase ungated", 3);
      cfg_rd("R9 user erase ungated", 63);
      cfg_wr(7, 32'h0);
      fl_rd("R9 flash untouched", 0);

      // full erase gating
      ctl_wr(8'h0C, 32'h1);
      cfg_rd("R8 disabled full erase", 7);
      fl_rd("R8 disabled full erase", 1);
      ctl_wr(8'h04, 32'h2);
      ctl_wr(8'h0C, 32'h3);
      cfg_rd("R8 wrong code", 7);
      ctl_wr(8'h0C, 32'h1);
      cfg_rd("R8 full erase user", 7);
      fl_rd("R8 full erase flash", 1);

      // random mix against the model
      for (int n = 0; n < 3000; n++) begin
         int unsigned op;
         op = $urandom_range(0, 11);
         case (op)
            0, 1, 2: fl_wr(int'($urandom_range(0, NW - 1)), $urandom);
            3: ctl_wr(8'h04, $urandom);
            4: ctl_wr(($urandom_range(0, 1) == 0) ? 8'h08 : 8'h10,
                      32'($urandom_range(0, 2 * AB)));
            5: ctl_wr(8'h0C, 32'($urandom_range(0, 40) == 0 ? 1 : $urandom_range(0, 3)));
            6: ctl_wr(8'h14, 32'($urandom_range(0, 3)));
            7: cfg_wr(int'($urandom_range(0, UW - 1)), $urandom);
            8: ctl_rd("R3 random control read", 8'($urandom_range(0, 31) * 4));
            9: cfg_rd("R10 random user read", int'($urandom_range(0, UW - 1)));
            default: fl_rd("R4 random flash read", int'($urandom_range(0, NW - 1)));
         endcase
      end
      full_cmp("R4 final compare");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule